// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one whole I2C master transaction, from the opening START to the final STOP. It works one level above a bit-level bus engine. A single `start` pulse captures a transaction descriptor. The descriptor holds a 16-bit address word, a flag word that selects the sequence type and the address width, and two buffer lengths. From that descriptor the block issues a chain of engine commands: start, repeated start, stop, write-byte and read-byte. It waits for the engine to finish each command before sending the next one.

Bytes to transmit are pulled from a ready/valid source. Bytes received are pushed to a ready/valid sink. Both carry a buffer index that tells which of the two buffers a byte belongs to. When the transaction ends, the block reports a signed 4-bit result code. The code tells whether the transaction completed, was refused by a NACK, was hit by a bus error, lost arbitration, or was rejected as badly described.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `cmd_valid`, `res_valid`, `tx_ready` and `rx_valid` are 0 and `res_code` is 0.
- R2: Flag bit 0 selects a plain write. The command chain is START, a write of `{addr[7:1],0}`, `len0` writes of bytes taken in order from the transmit port, then STOP. With `len0`=0 only the address byte is sent. Command codes on `cmd_op` are START=1, RSTART=2, STOP=3, WRITE=4, READ=5. `cmd_byte` is 0 for every command other than WRITE.
- R3: Flag bit 1 selects a plain read. The chain is START, a write of `{addr[7:1],1}`, `len0` reads, then STOP. Each received byte leaves on the receive port with `buf_idx`=0.
- R4: Flag bit 2 selects write-then-read. The chain is START, write `{addr[7:1],0}`, `len0` data writes, RSTART, write `{addr[7:1],1}`, `len1` reads with `buf_idx`=1, then STOP.
- R5: Flag bit 3 selects a two-buffer write. The `len0` bytes and then the `len1` bytes are written back to back, with no RSTART, then STOP.
- R6: Exactly one of flag bits 3..0 must be set. A read phase must also have a non-zero length (`len0` for a read, `len1` for write-then-read). Otherwise the result is -4 (0xC) and no command is issued.
- R7: Every READ command carries `cmd_nack`=0 except the last read of the phase, which carries `cmd_nack`=1.
- R8: Flag bit 4 selects 10-bit addressing. The header byte is `{11110,addr[9:8],rw}` and it is followed by a write of `addr[7:0]`. After an RSTART only the header is sent again, with rw=1. A 10-bit plain read sends the header with rw=0, then the low byte, then RSTART, then the header with rw=1, then the reads.
- R9: A NACK (`eng_ack`=0) on any address or data write makes the next command a STOP. The result is then -1 (0xF).
- R10: When a command completes with `eng_arb_lost`, the transaction ends at once with result -3 (0xD) and no further command is issued.
- R11: When a command completes with `eng_bus_err` and no arbitration loss, the transaction ends at once with result -2 (0xE) and no further command is issued.
- R12: While a transaction runs, `busy`=1 and `res_code`=1. At the end, `res_valid` pulses for one cycle with the final code, which is held afterwards. A successful transaction ends with 0.
- R13: At most one command is outstanding until `eng_done`. A received byte stays on `rx_data` with `rx_valid` held until `rx_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture descriptor and begin (ignored while busy) |
| cfg_addr | input | 16 | Address word (7-bit: bits 7..1; 10-bit: bits 9..0) |
| cfg_flags | input | 16 | Sequence type and address-width flags |
| cfg_len0 | input | LEN_W | Byte count of buffer 0 |
| cfg_len1 | input | LEN_W | Byte count of buffer 1 |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | One-cycle pulse at the end of a transaction |
| res_code | output | 4 | Two's-complement result code |
| buf_idx | output | 1 | Buffer that the current data byte belongs to |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Block requests a transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Sink accepts the received byte |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte to write |
| cmd_nack | output | 1 | For a read, answer with NACK instead of ACK |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_ack | input | 1 | Slave acknowledged the written byte |
| eng_rdata | input | 8 | Byte read by the engine |
| eng_arb_lost | input | 1 | Arbitration lost during the command |
| eng_bus_err | input | 1 | Misplaced START or STOP seen during the command |

## Verification
The assertions assume that the engine raises `eng_done` only in answer to an issued command, for one cycle, and never in the same cycle as a new `cmd_valid`. They also assume that `eng_ack` and the two fault flags are meaningful only alongside `eng_done`. The bench engine model keeps to this: it answers each command exactly two cycles after seeing it and drives all response lines only during that single cycle. The transmit source is always valid. The receive sink is throttled in some runs to exercise the hold rule.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_STOP   = 3'd3,
    OP_WRITE  = 3'd4,
    OP_READ   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    SEQ_WR   = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WRRD = 2'd2,
    SEQ_WRWR = 2'd3
  } seq_e;

  typedef enum logic [2:0] {
    STP_START, STP_HDR, STP_LOW, STP_TX0, STP_TX1, STP_RSTART, STP_RX, STP_STOP
  } step_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_WAIT, ST_DRAIN
  } state_e;

  localparam logic [3:0] RC_BUSY   = 4'h1;
  localparam logic [3:0] RC_DONE   = 4'h0;
  localparam logic [3:0] RC_NACK   = 4'hF;
  localparam logic [3:0] RC_BUSERR = 4'hE;
  localparam logic [3:0] RC_ARB    = 4'hD;
  localparam logic [3:0] RC_USAGE  = 4'hC;

  localparam int FLG_W = 5;
  localparam int FB_TEN = 4;
endpackage

// File: rtl/xseq_decode.sv
module xseq_decode
  import xseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [FLG_W-1:0] flags,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  output seq_e             seq,
  output logic             ten,
  output logic             fault,
  output logic [LEN_W-1:0] rd_len,
  output logic             rd_buf,
  output logic             hdr_read,
  output logic             need_sr
);
  logic [3:0] kind;
  logic       kind_bad;

  assign kind     = flags[3:0];
  assign ten      = flags[FB_TEN];
  assign kind_bad = ($countones(kind) != 1);

  always_comb begin
    seq = SEQ_WR;
    unique case (1'b1)
      kind[1]: seq = SEQ_RD;
      kind[2]: seq = SEQ_WRRD;
      kind[3]: seq = SEQ_WRWR;
      default: seq = SEQ_WR;
    endcase
  end

  always_comb begin
    rd_len = '0;
    rd_buf = 1'b0;
    if (seq == SEQ_RD) rd_len = len0;
    if (seq == SEQ_WRRD) begin
      rd_len = len1;
      rd_buf = 1'b1;
    end
  end

  assign fault    = kind_bad ||
                    (((seq == SEQ_RD) || (seq == SEQ_WRRD)) && (rd_len == '0));
  assign hdr_read = (seq == SEQ_RD) && !ten;
  assign need_sr  = (seq == SEQ_WRRD) || ((seq == SEQ_RD) && ten);
endmodule

// File: rtl/xseq_addr.sv
module xseq_addr (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rw,
  output logic [7:0] hdr,
  output logic [7:0] lo
);
  localparam logic [4:0] TEN_MARK = 5'b11110;

  assign hdr = ten ? {TEN_MARK, addr[9:8], rw} : {addr[7:1], rw};
  assign lo  = addr[7:0];
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import xseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [15:0]      cfg_addr,
  input  logic [15:0]      cfg_flags,
  input  logic [LEN_W-1:0] cfg_len0,
  input  logic [LEN_W-1:0] cfg_len1,
  output logic             busy,
  output logic             res_valid,
  output logic [3:0]       res_code,
  output logic             buf_idx,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rdata,
  input  logic             eng_arb_lost,
  input  logic             eng_bus_err
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  state_e           state;
  step_e            stp;
  logic [LEN_W-1:0] cnt;
  logic             in_sr;
  logic [3:0]       code_r;
  logic [9:0]       a_r;
  logic [FLG_W-1:0] f_r;
  logic [LEN_W-1:0] l0_r, l1_r;

  logic unused_cfg;
  assign unused_cfg = ^{cfg_addr[15:10], cfg_flags[15:FLG_W]};

  seq_e             seq;
  logic             ten, fault, rd_buf, hdr_read, need_sr;
  logic [LEN_W-1:0] rd_len;
  logic [7:0]       hdr_b, lo_b;

  xseq_decode #(.LEN_W(LEN_W)) u_dec (
    .flags(f_r), .len0(l0_r), .len1(l1_r), .seq(seq), .ten(ten), .fault(fault),
    .rd_len(rd_len), .rd_buf(rd_buf), .hdr_read(hdr_read), .need_sr(need_sr)
  );

  xseq_addr u_addr (
    .addr(a_r), .ten(ten), .rw(in_sr | hdr_read), .hdr(hdr_b), .lo(lo_b)
  );

  // Step that follows the last data write of buffer 0
  step_e            aft_stp, dat_stp, nstp;
  logic [LEN_W-1:0] aft_cnt, dat_cnt, ncnt;

  always_comb begin
    aft_stp = STP_STOP;
    aft_cnt = cnt;
    if ((seq == SEQ_WRWR) && (l1_r != '0)) begin
      aft_stp = STP_TX1;
      aft_cnt = l1_r;
    end else if (need_sr) begin
      aft_stp = STP_RSTART;
    end
  end

  // First step after the opening address bytes
  always_comb begin
    dat_stp = aft_stp;
    dat_cnt = aft_cnt;
    if (seq == SEQ_RD) begin
      if (need_sr) begin
        dat_stp = STP_RSTART;
        dat_cnt = cnt;
      end else begin
        dat_stp = STP_RX;
        dat_cnt = rd_len;
      end
    end else if (l0_r != '0) begin
      dat_stp = STP_TX0;
      dat_cnt = l0_r;
    end
  end

  always_comb begin
    nstp = STP_STOP;
    ncnt = cnt;
    unique case (stp)
      STP_START:  nstp = STP_HDR;
      STP_HDR: begin
        if (in_sr) begin
          nstp = STP_RX;
          ncnt = rd_len;
        end else if (ten) begin
          nstp = STP_LOW;
        end else begin
          nstp = dat_stp;
          ncnt = dat_cnt;
        end
      end
      STP_LOW: begin
        nstp = dat_stp;
        ncnt = dat_cnt;
      end
      STP_TX0: begin
        if (cnt > ONE) begin
          nstp = STP_TX0;
          ncnt = cnt - ONE;
        end else begin
          nstp = aft_stp;
          ncnt = aft_cnt;
        end
      end
      STP_TX1: begin
        if (cnt > ONE) begin
          nstp = STP_TX1;
          ncnt = cnt - ONE;
        end
      end
      STP_RSTART: nstp = STP_HDR;
      STP_RX: begin
        if (cnt > ONE) begin
          nstp = STP_RX;
          ncnt = cnt - ONE;
        end
      end
      default:    nstp = STP_STOP;
    endcase
  end

  // Command produced on entering the next step
  op_e  e_op;
  logic [7:0] e_byte;
  logic e_nack, e_fetch, e_buf;

  always_comb begin
    e_op    = OP_STOP;
    e_byte  = 8'h00;
    e_nack  = 1'b0;
    e_fetch = 1'b0;
    e_buf   = buf_idx;
    unique case (nstp)
      STP_HDR: begin
        e_op   = OP_WRITE;
        e_byte = hdr_b;
      end
      STP_LOW: begin
        e_op   = OP_WRITE;
        e_byte = lo_b;
      end
      STP_TX0: begin
        e_fetch = 1'b1;
        e_buf   = 1'b0;
      end
      STP_TX1: begin
        e_fetch = 1'b1;
        e_buf   = 1'b1;
      end
      STP_RSTART: e_op = OP_RSTART;
      STP_RX: begin
        e_op   = OP_READ;
        e_nack = (ncnt == ONE);
        e_buf  = rd_buf;
      end
      default:    e_op = OP_STOP;
    endcase
  end

  logic wr_step, ok_done, adv;
  assign wr_step = (stp == STP_HDR) || (stp == STP_LOW) || (stp == STP_TX0) || (stp == STP_TX1);
  assign ok_done = eng_done && !eng_arb_lost && !eng_bus_err;
  assign adv = ((state == ST_WAIT) && ok_done && (stp != STP_STOP) && (stp != STP_RX) &&
                !(wr_step && !eng_ack)) ||
               ((state == ST_DRAIN) && rx_ready);

  assign tx_ready = (state == ST_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stp       <= STP_START;
      cnt       <= '0;
      in_sr     <= 1'b0;
      code_r    <= RC_DONE;
      a_r       <= '0;
      f_r       <= '0;
      l0_r      <= '0;
      l1_r      <= '0;
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_code  <= RC_DONE;
      buf_idx   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= 8'h00;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_byte  <= 8'h00;
      cmd_nack  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            a_r      <= cfg_addr[9:0];
            f_r      <= cfg_flags[FLG_W-1:0];
            l0_r     <= cfg_len0;
            l1_r     <= cfg_len1;
            in_sr    <= 1'b0;
            code_r   <= RC_DONE;
            busy     <= 1'b1;
            res_code <= RC_BUSY;
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (fault) begin
            busy      <= 1'b0;
            res_valid <= 1'b1;
            res_code  <= RC_USAGE;
            state     <= ST_IDLE;
          end else begin
            stp       <= STP_START;
            cmd_valid <= 1'b1;
            cmd_op    <= OP_START;
            cmd_byte  <= 8'h00;
            cmd_nack  <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_FETCH: begin
          if (tx_valid) begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_WRITE;
            cmd_byte  <= tx_data;
            cmd_nack  <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            if (eng_arb_lost || eng_bus_err) begin
              busy      <= 1'b0;
              res_valid <= 1'b1;
              res_code  <= eng_arb_lost ? RC_ARB : RC_BUSERR;
              state     <= ST_IDLE;
            end else if (stp == STP_STOP) begin
              busy      <= 1'b0;
              res_valid <= 1'b1;
              res_code  <= code_r;
              state     <= ST_IDLE;
            end else if (wr_step && !eng_ack) begin
              code_r    <= RC_NACK;
              stp       <= STP_STOP;
              cmd_valid <= 1'b1;
              cmd_op    <= OP_STOP;
              cmd_byte  <= 8'h00;
              cmd_nack  <= 1'b0;
            end else if (stp == STP_RX) begin
              rx_valid <= 1'b1;
              rx_data  <= eng_rdata;
              state    <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (rx_ready) rx_valid <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase

      if (adv) begin
        stp     <= nstp;
        cnt     <= ncnt;
        buf_idx <= e_buf;
        if (nstp == STP_RSTART) in_sr <= 1'b1;
        if (e_fetch) begin
          state <= ST_FETCH;
        end else begin
          cmd_valid <= 1'b1;
          cmd_op    <= e_op;
          cmd_byte  <= e_byte;
          cmd_nack  <= e_nack;
          state     <= ST_WAIT;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk
  import xseq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       res_valid,
  input logic [3:0] res_code,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       eng_done,
  input logic       eng_ack,
  input logic       eng_arb_lost,
  input logic       eng_bus_err
);
  logic       pend_r;
  logic [2:0] last_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_r  <= 1'b0;
      last_op <= OP_NONE;
    end else begin
      if (cmd_valid) begin
        pend_r  <= 1'b1;
        last_op <= cmd_op;
      end else if (eng_done) begin
        pend_r <= 1'b0;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !cmd_valid && !res_valid && !rx_valid && res_code == RC_DONE)); // R1

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !pend_r); // R13

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R13

  AST_BUSY_CODE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (res_code == RC_BUSY)); // R12

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R12

  AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid); // R12

  AST_NACK_STOP: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done && !eng_ack && !eng_arb_lost && !eng_bus_err && last_op == OP_WRITE)
      |=> (cmd_valid && cmd_op == OP_STOP)); // R9

  AST_ARB_END: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done && eng_arb_lost) |=> (res_valid && res_code == RC_ARB && !cmd_valid)); // R10

  AST_BUSERR_END: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done && eng_bus_err && !eng_arb_lost)
      |=> (res_valid && res_code == RC_BUSERR && !cmd_valid)); // R11
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .res_valid(res_valid), .res_code(res_code),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_ready(rx_ready), .eng_done(eng_done), .eng_ack(eng_ack),
  .eng_arb_lost(eng_arb_lost), .eng_bus_err(eng_bus_err)
);

// File: tb/i2c_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_xfer_seq_tb_top;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, start = 1'b0;
  logic [15:0] cfg_addr = '0, cfg_flags = '0;
  logic [LEN_W-1:0] cfg_len0 = '0, cfg_len1 = '0;
  logic busy, res_valid, buf_idx, tx_ready, rx_valid, cmd_valid, cmd_nack;
  logic [3:0] res_code;
  logic [7:0] rx_data, cmd_byte;
  logic [2:0] cmd_op;
  logic tx_valid = 1'b1, rx_ready = 1'b1;
  logic [7:0] tx_data;
  logic eng_done = 0, eng_ack = 0, eng_arb_lost = 0, eng_bus_err = 0;
  logic [7:0] eng_rdata = '0;

  i2c_xfer_seq #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_addr(cfg_addr), .cfg_flags(cfg_flags),
    .cfg_len0(cfg_len0), .cfg_len1(cfg_len1), .busy(busy), .res_valid(res_valid),
    .res_code(res_code), .buf_idx(buf_idx), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .eng_arb_lost(eng_arb_lost), .eng_bus_err(eng_bus_err)
  );

  int checks = 0, errors = 0;
  logic [11:0] exp_cmd[$];
  logic [8:0]  exp_rx[$];
  logic [3:0]  exp_code;
  string cur_req = "R1";
  int nack_i = -1, arb_i = -1, berr_i = -1;
  int cmd_n = 0, last_idx = 0, pend = 0, tx_n = 0, cyc = 0;
  bit tx_taken = 0, stall = 0, got_res = 0;

  assign tx_data = 8'h50 + 8'(tx_n);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor and engine model, both away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (tx_taken) tx_n++;
    tx_taken = tx_ready && tx_valid;
    eng_done = 0; eng_ack = 0; eng_arb_lost = 0; eng_bus_err = 0;
    if (pend != 0) begin
      pend--;
      if (pend == 0) begin
        eng_done     = 1;
        eng_ack      = (last_idx != nack_i);
        eng_arb_lost = (last_idx == arb_i);
        eng_bus_err  = (last_idx == berr_i);
        eng_rdata    = 8'h30 + 8'(last_idx);
      end
    end
    if (cmd_valid && !rst) begin
      if (exp_cmd.size() == 0) chk(0, {cur_req, " unexpected cmd"}, {cmd_op, cmd_nack, cmd_byte}, 0);
      else begin
        logic [11:0] e;
        e = exp_cmd.pop_front();
        chk({cmd_op, cmd_nack, cmd_byte} == e, {cur_req, " cmd"}, {cmd_op, cmd_nack, cmd_byte}, e);
      end
      last_idx = cmd_n;
      cmd_n++;
      pend = 2;
    end
    rx_ready = stall ? cyc[1] : 1'b1;
    if (rx_valid && rx_ready && !rst) begin
      if (exp_rx.size() == 0) chk(0, {cur_req, " unexpected rx"}, {buf_idx, rx_data}, 0);
      else begin
        logic [8:0] r;
        r = exp_rx.pop_front();
        chk({buf_idx, rx_data} == r, {cur_req, " rx byte"}, {buf_idx, rx_data}, r);
      end
    end
    if (res_valid && !rst) begin
      chk(res_code == exp_code, {cur_req, " result"}, res_code, exp_code);
      got_res = 1;
    end
  end

  // Driver: builds the expected chain from the requirements
  task automatic run(string req, logic [15:0] addr, logic [15:0] flags, int l0, int l1,
                     int nk, int ar, int be);
    logic [11:0] ideal[$];
    logic [7:0] hw, hr;
    bit ten, fault;
    logic [3:0] code;
    int k;
    ten   = flags[4];
    fault = ($countones(flags[3:0]) != 1) || (flags[1] && l0 == 0) || (flags[2] && l1 == 0);
    hw = ten ? {5'b11110, addr[9:8], 1'b0} : {addr[7:1], 1'b0};
    hr = ten ? {5'b11110, addr[9:8], 1'b1} : {addr[7:1], 1'b1};
    code = 4'h0;
    if (fault) code = 4'hC; // R6
    else begin
      ideal.push_back({3'd1, 1'b0, 8'h00});
      ideal.push_back({3'd4, 1'b0, (flags[1] && !ten) ? hr : hw});
      if (ten) ideal.push_back({3'd4, 1'b0, addr[7:0]}); // R8
      k = 0;
      if (flags[1]) begin
        if (ten) begin
          ideal.push_back({3'd2, 1'b0, 8'h00});
          ideal.push_back({3'd4, 1'b0, hr});
        end
        for (int i = 0; i < l0; i++) ideal.push_back({3'd5, i == l0 - 1, 8'h00}); // R7
      end else begin
        for (int i = 0; i < l0; i++) begin ideal.push_back({3'd4, 1'b0, 8'h50 + 8'(k)}); k++; end
        if (flags[3]) for (int i = 0; i < l1; i++) begin ideal.push_back({3'd4, 1'b0, 8'h50 + 8'(k)}); k++; end
        if (flags[2]) begin
          ideal.push_back({3'd2, 1'b0, 8'h00});
          ideal.push_back({3'd4, 1'b0, hr});
          for (int i = 0; i < l1; i++) ideal.push_back({3'd5, i == l1 - 1, 8'h00});
        end
      end
      ideal.push_back({3'd3, 1'b0, 8'h00});
      for (int i = 0; i < ideal.size(); i++) begin
        exp_cmd.push_back(ideal[i]);
        if (i == ar) begin code = 4'hD; break; end      // R10
        if (i == be) begin code = 4'hE; break; end      // R11
        if (ideal[i][11:9] == 3'd4 && i == nk) begin    // R9
          exp_cmd.push_back({3'd3, 1'b0, 8'h00});
          code = 4'hF;
          break;
        end
        if (ideal[i][11:9] == 3'd5) exp_rx.push_back({flags[2], 8'h30 + 8'(i)});
      end
    end
    @(negedge clk);
    cur_req = req; exp_code = code; nack_i = nk; arb_i = ar; berr_i = be;
    cmd_n = 0; tx_n = 0; tx_taken = 0; got_res = 0;
    cfg_addr = addr; cfg_flags = flags; cfg_len0 = LEN_W'(l0); cfg_len1 = LEN_W'(l1);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy && res_code == 4'h1, "R12 busy while running", {busy, res_code}, 5'h11);
    while (!got_res) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && res_code == code, "R12 code held", {busy, res_code}, code);
    chk(exp_cmd.size() == 0, {req, " commands left"}, exp_cmd.size(), 0);
    chk(exp_rx.size() == 0, {req, " rx left"}, exp_rx.size(), 0);
    exp_cmd.delete();
    exp_rx.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !cmd_valid && !res_valid && !tx_ready && !rx_valid && res_code == 0,
        "R1 reset state", {busy, cmd_valid, res_code}, 0);
    run("R2 write",       16'h00A4, 16'h0001, 3, 0, -1, -1, -1);
    run("R2 zero write",  16'h0052, 16'h0001, 0, 0, -1, -1, -1);
    stall = 1;
    run("R3 R7 read",     16'h0090, 16'h0002, 3, 0, -1, -1, -1);
    run("R4 write-read",  16'h0036, 16'h0004, 2, 2, -1, -1, -1);
    stall = 0;
    run("R5 write-write", 16'h0010, 16'h0008, 2, 3, -1, -1, -1);
    run("R5 empty buf1",  16'h0010, 16'h0008, 1, 0, -1, -1, -1);
    run("R8 ten write",   16'h02C5, 16'h0011, 2, 0, -1, -1, -1);
    run("R8 ten read",    16'h0155, 16'h0012, 1, 0, -1, -1, -1);
    run("R8 ten wr-rd",   16'h03F0, 16'h0014, 1, 2, -1, -1, -1);
    run("R9 addr nack",   16'h0044, 16'h0001, 2, 0, 1, -1, -1);
    run("R9 data nack",   16'h0044, 16'h0001, 3, 0, 3, -1, -1);
    run("R9 sr nack",     16'h0044, 16'h0004, 1, 1, 4, -1, -1);
    run("R10 arb lost",   16'h0060, 16'h0001, 3, 0, -1, 2, -1);
    run("R11 bus error",  16'h0060, 16'h0002, 2, 0, -1, -1, 2);
    run("R6 read len 0",  16'h0060, 16'h0002, 0, 0, -1, -1, -1);
    run("R6 wr-rd len 0", 16'h0060, 16'h0004, 2, 0, -1, -1, -1);
    run("R6 two types",   16'h0060, 16'h0003, 1, 1, -1, -1, -1);
    run("R6 no type",     16'h0060, 16'h0010, 1, 1, -1, -1, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule